// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sends commands to a memory card. Software writes a 16-bit command word and a 32-bit argument through a small register write port. The block decodes the command word and sends the command index, the argument and the transfer attributes to the card side as a one-cycle request strobe. It then waits for the card side to return a response: a byte stream of up to 16 bytes and a byte count.

When the response arrives, the block compares the byte count with the length that the response type requires. It stores the bytes as eight 16-bit response words and sets sticky status bits: done, stop-command done, timeout, a card-not-ready flag for operating-condition responses, and a card-error flag. The card-error flag comes from a card-status word masked with a mask for each type. Software clears status bits by writing ones to them. CRC checking and the card itself lie outside this block.

Top module: `mmc_cmd_engine`

## Requirements
- R1: The command word is decoded as follows. Bits 5:0 are the index. Bit 7 is the init flag. Bits 10:8 are the response type. Bit 11 is the busy flag. Bits 13:12 are the command kind. Bit 15 is the data direction. Write selects are 0 for command, 1 for argument low, 2 for argument high and 3 for status clear.
- R2: A command write is ignored while `ctl_enable` is low or while `busy` is high. It raises no request and changes no status.
- R3: An accepted command write clears all eight response words. The words read as zero in the cycle after the write.
- R4: An accepted command with the init flag set and index 0 issues no request and leaves `busy` low. It sets only status bit 0, in the cycle after the write.
- R5: Any other accepted command pulses `req_valid` for exactly one cycle, in the cycle after the write. The request carries the index, argument, direction, kind and busy flag. `busy` is high from that cycle until the cycle after `rsp_valid` is sampled.
- R6: Each argument write replaces only its own 16-bit half of `req_arg`.
- R7: Types 1, 3 and 6 need at least 4 bytes, and type 2 needs 16. A shorter response sets status bit 7 and nothing else, and stores no words. Other types need no length and store no words.
- R8: For a type 3 response, status bit 12 is set if bit 31 of bytes 0..3 (taken big-endian) is clear.
- R9: Status bit 14 is set when the card-status word ANDed with the type's error mask is nonzero. Otherwise a capture clears it. The card-status word is bytes 0..3 big-endian for type 1 (mask FDF90000h), and {byte2, byte3} for type 6 (mask 0000E008h).
- R10: Byte 2k (high) and byte 2k+1 (low) form response word 7-k. Byte i arrives on `rsp_bytes[127-8i -: 8]`.
- R11: A capture without timeout sets status bit 0, and also sets bit 2 when the index is 12.
- R12: A status-clear write clears the status bits written as one. If a bit is set and cleared in the same cycle, the set wins. `rsp_valid` while `busy` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; command writes are ignored when low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 arg low, 2 arg high, 3 status clear |
| wr_data | input | 16 | Write data |
| req_valid | output | 1 | One-cycle request strobe to the card side |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_dir | output | 1 | Data direction flag |
| req_kind | output | 2 | Command kind field |
| req_busy | output | 1 | Busy-signalling flag of the command |
| rsp_valid | input | 1 | Response available |
| rsp_len | input | 5 | Response byte count, 0..16 |
| rsp_bytes | input | 128 | Response bytes, byte 0 in bits 127:120 |
| rsp_sel | input | 3 | Response word select |
| rsp_word | output | 16 | Selected response word |
| busy | output | 1 | Command in flight |
| status | output | 16 | Sticky status bits |

## Verification
The request strobe, the `busy` rise and the response-word clear all follow an accepted command write by one clock edge. Status, stored words and the `busy` fall follow the edge that samples `rsp_valid` by one edge. `rsp_word` is combinational in `rsp_sel`. The bench drives every input on the falling edge. Each write or response task ends on the next falling edge, exactly one rising edge later, and the checks sample there. The single-cycle width of the strobe is checked one falling edge further on.

// File: rtl/mmc_cmd_pkg.sv
// Shared constants and types for the card command engine.
// Assumes a 16-byte maximum response and eight 16-bit response words.
package mmc_cmd_pkg;
    localparam int RSP_BYTES = 16;
    localparam int RSP_WORDS = RSP_BYTES / 2;
    localparam int LEN_W     = $clog2(RSP_BYTES + 1);
    localparam int SEL_W     = $clog2(RSP_WORDS);

    // Status bit positions
    localparam int ST_DONE  = 0;
    localparam int ST_STOP  = 2;
    localparam int ST_TMO   = 7;
    localparam int ST_NRDY  = 12;
    localparam int ST_ERR   = 14;

    // Command word bit positions used before decode
    localparam int CMD_INIT_BIT = 7;
    localparam logic [5:0] STOP_INDEX = 6'd12;

    // Response types with length rules
    localparam logic [2:0] RT_SHORT = 3'd1;
    localparam logic [2:0] RT_LONG  = 3'd2;
    localparam logic [2:0] RT_OCR   = 3'd3;
    localparam logic [2:0] RT_RCA   = 3'd6;

    typedef enum logic [1:0] {
        SEL_CMD    = 2'd0,
        SEL_ARG_LO = 2'd1,
        SEL_ARG_HI = 2'd2,
        SEL_ST_CLR = 2'd3
    } wr_target_e;

    typedef struct packed {
        logic       dir;
        logic [1:0] kind;
        logic       busy_f;
        logic [2:0] rtype;
        logic [5:0] index;
    } cmd_fields_t;
endpackage

// File: rtl/mmc_cmd_decode.sv
// Splits a raw 16-bit command word into its fields.
// Purely combinational; bits 6 and 14 carry no meaning.
module mmc_cmd_decode
    import mmc_cmd_pkg::*;
(
    input  logic [15:0] word_i,
    output cmd_fields_t fld_o,
    output logic        init_o
);
    // Field extraction
    always_comb begin
        fld_o.index  = word_i[5:0];
        fld_o.rtype  = word_i[10:8];
        fld_o.busy_f = word_i[11];
        fld_o.kind   = word_i[13:12];
        fld_o.dir    = word_i[15];
        init_o       = word_i[CMD_INIT_BIT];
    end
endmodule

// File: rtl/mmc_rsp_eval.sv
// Judges a returned response: length check, card-status word extraction,
// error masking and the status bits to set. Combinational.
// Assumes the byte count never exceeds RSP_BYTES.
module mmc_rsp_eval
    import mmc_cmd_pkg::*;
#(
    parameter logic [31:0] ERR_MASK_SHORT = 32'hFDF9_0000,
    parameter logic [31:0] ERR_MASK_RCA   = 32'h0000_E008
) (
    input  logic [2:0]             rtype_i,
    input  logic [5:0]             index_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [8*RSP_BYTES-1:0] bytes_i,
    output logic                   store_o,
    output logic                   err_o,
    output logic [15:0]            set_o
);
    localparam int TOP = 8 * RSP_BYTES - 1;

    logic [LEN_W-1:0] need;
    logic [31:0]      card_word;
    logic [31:0]      mask;
    logic             tmo;

    // Per-type length requirement, status word and error mask
    always_comb begin
        need      = '0;
        mask      = '0;
        card_word = bytes_i[TOP -: 32];
        case (rtype_i)
            RT_SHORT: begin need = LEN_W'(4);  mask = ERR_MASK_SHORT; end
            RT_LONG:  begin need = LEN_W'(16); end
            RT_OCR:   begin need = LEN_W'(4);  end
            RT_RCA:   begin
                need      = LEN_W'(4);
                mask      = ERR_MASK_RCA;
                card_word = {16'h0000, bytes_i[TOP-16 -: 16]};
            end
            default:  need = '0;
        endcase
    end

    // Outcome and status bits to set
    always_comb begin
        tmo     = (need != '0) && (len_i < need);
        store_o = (need != '0) && !tmo;
        err_o   = !tmo && |(card_word & mask);
        set_o   = '0;
        if (tmo) begin
            set_o[ST_TMO] = 1'b1;
        end else begin
            set_o[ST_DONE] = 1'b1;
            if (index_i == STOP_INDEX)              set_o[ST_STOP] = 1'b1;
            if (rtype_i == RT_OCR && !card_word[31]) set_o[ST_NRDY] = 1'b1;
            if (err_o)                              set_o[ST_ERR]  = 1'b1;
        end
    end
endmodule

// File: rtl/mmc_rsp_regs.sv
// Bank of response words with clear, load and read selection.
// Word j takes bytes_i[16j +: 16], which puts byte pair 2k/2k+1 in word 7-k.
module mmc_rsp_regs
    import mmc_cmd_pkg::*;
#(
    parameter int WORDS = RSP_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     load_i,
    input  logic [16*WORDS-1:0]      bytes_i,
    input  logic [$clog2(WORDS)-1:0] sel_i,
    output logic [15:0]              word_o
);
    logic [15:0] bank [WORDS];

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        // Holds one response word; a load takes precedence over a clear
        always_ff @(posedge clk) begin
            if (!rst_n)      bank[j] <= '0;
            else if (load_i) bank[j] <= bytes_i[16*j +: 16];
            else if (clr_i)  bank[j] <= '0;
        end
    end

    assign word_o = bank[sel_i];
endmodule

// File: rtl/mmc_cmd_engine.sv
// Top of the command engine: accepts register writes, issues a request,
// captures the response and keeps the sticky status.
// Assumes the card side answers each request with one rsp_valid pulse.
module mmc_cmd_engine
    import mmc_cmd_pkg::*;
#(
    parameter logic [31:0] ERR_MASK_SHORT = 32'hFDF9_0000,
    parameter logic [31:0] ERR_MASK_RCA   = 32'h0000_E008
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_enable,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [15:0]            wr_data,
    output logic                   req_valid,
    output logic [5:0]             req_index,
    output logic [31:0]            req_arg,
    output logic                   req_dir,
    output logic [1:0]             req_kind,
    output logic                   req_busy,
    input  logic                   rsp_valid,
    input  logic [LEN_W-1:0]       rsp_len,
    input  logic [8*RSP_BYTES-1:0] rsp_bytes,
    input  logic [SEL_W-1:0]       rsp_sel,
    output logic [15:0]            rsp_word,
    output logic                   busy,
    output logic [15:0]            status
);
    cmd_fields_t fld_w, cmd_q;
    logic        init_w;
    logic        accept, init_only, launch, capture;
    logic        busy_q, req_q;
    logic        ev_store, ev_err;
    logic [15:0] ev_set, st_q, st_set, st_clr;

    mmc_cmd_decode u_dec (.word_i(wr_data), .fld_o(fld_w), .init_o(init_w));

    assign accept    = wr_en && (wr_sel == SEL_CMD) && ctl_enable && !busy_q;
    assign init_only = accept && init_w && (fld_w.index == '0);
    assign launch    = accept && !init_only;
    assign capture   = busy_q && rsp_valid;

    // Latches the accepted command fields
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= fld_w;
    end

    // Argument halves, each write touching only its half
    always_ff @(posedge clk) begin
        if (!rst_n) req_arg <= '0;
        else if (wr_en && wr_sel == SEL_ARG_LO) req_arg[15:0]  <= wr_data;
        else if (wr_en && wr_sel == SEL_ARG_HI) req_arg[31:16] <= wr_data;
    end

    // Request strobe and in-flight flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            req_q <= launch;
            if (launch)       busy_q <= 1'b1;
            else if (capture) busy_q <= 1'b0;
        end
    end

    mmc_rsp_eval #(
        .ERR_MASK_SHORT(ERR_MASK_SHORT),
        .ERR_MASK_RCA  (ERR_MASK_RCA)
    ) u_eval (
        .rtype_i(cmd_q.rtype),
        .index_i(cmd_q.index),
        .len_i  (rsp_len),
        .bytes_i(rsp_bytes),
        .store_o(ev_store),
        .err_o  (ev_err),
        .set_o  (ev_set)
    );

    mmc_rsp_regs #(.WORDS(RSP_WORDS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .load_i(capture && ev_store),
        .bytes_i(rsp_bytes),
        .sel_i (rsp_sel),
        .word_o(rsp_word)
    );

    // Set and clear terms for the sticky status
    always_comb begin
        st_set = '0;
        st_clr = '0;
        if (wr_en && wr_sel == SEL_ST_CLR) st_clr = wr_data;
        if (capture) begin
            st_set = ev_set;
            if (!ev_err) st_clr[ST_ERR] = 1'b1;
        end
        if (init_only) st_set[ST_DONE] = 1'b1;
    end

    // Sticky status register; a set wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~st_clr) | st_set;
    end

    assign req_valid = req_q;
    assign req_index = cmd_q.index;
    assign req_dir   = cmd_q.dir;
    assign req_kind  = cmd_q.kind;
    assign req_busy  = cmd_q.busy_f;
    assign busy      = busy_q;
    assign status    = st_q;
endmodule

// File: rtl/mmc_cmd_engine_chk.sv
// Protocol checker for the command engine, bound to every instance.
module mmc_cmd_engine_chk
    import mmc_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_enable,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [15:0] wr_data,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        busy,
    input logic [15:0] status
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_sel == SEL_CMD);

    a_r2_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (!ctl_enable || busy)) |=> !req_valid);

    a_r4_init_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ctl_enable && !busy && wr_data[CMD_INIT_BIT] && wr_data[5:0] == 6'd0)
        |=> (!req_valid && !busy && status[ST_DONE]));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r5_busy_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_valid) |=> busy);

    a_r5_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_valid) |=> !busy);

    a_r11_stop_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_STOP]) |-> status[ST_DONE]);
endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_enable(ctl_enable),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .status    (status)
);

// File: tb/mmc_cmd_engine_tb.sv
// Directed bench for the command engine: one task per scenario.
module mmc_cmd_engine_tb;
    import mmc_cmd_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_enable = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [15:0]  wr_data = '0;
    logic         req_valid;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         req_dir;
    logic [1:0]   req_kind;
    logic         req_busy;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;
    logic [2:0]   rsp_sel = '0;
    logic [15:0]  rsp_word;
    logic         busy;
    logic [15:0]  status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmc_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
        .req_dir(req_dir), .req_kind(req_kind), .req_busy(req_busy),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes),
        .rsp_sel(rsp_sel), .rsp_word(rsp_word), .busy(busy), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bytes 0..3 given, bytes 4..15 = base+0 .. base+11
    function automatic logic [127:0] mk(input logic [7:0] b0, b1, b2, b3, base);
        logic [127:0] v;
        v = {b0, b1, b2, b3, 96'h0};
        for (int i = 4; i < 16; i++) v[127-8*i -: 8] = base + 8'(i - 4);
        return v;
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic respond(input logic [4:0] len, input logic [127:0] bytes);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_len = len; rsp_bytes = bytes;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic word_at(input logic [2:0] sel, output logic [15:0] w);
        rsp_sel = sel;
        #1;
        w = rsp_word;
    endtask

    task automatic clear_status();
        write_reg(SEL_ST_CLR, 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [15:0] w;
        chk("R12 reset status", 32'(status), 32'h0);
        chk("R5 reset busy", 32'(busy), 32'h0);
        chk("R5 reset req", 32'(req_valid), 32'h0);
        word_at(3'd7, w);
        chk("R3 reset word7", 32'(w), 32'h0);
    endtask

    task automatic t_disabled();
        ctl_enable = 1'b0;
        write_reg(SEL_CMD, 16'h0111);
        chk("R2 disabled no req", 32'(req_valid), 32'h0);
        chk("R2 disabled no busy", 32'(busy), 32'h0);
        chk("R2 disabled no status", 32'(status), 32'h0);
        ctl_enable = 1'b1;
    endtask

    task automatic t_arg();
        write_reg(SEL_ARG_LO, 16'h1234);
        write_reg(SEL_ARG_HI, 16'hABCD);
        chk("R6 arg both", req_arg, 32'hABCD_1234);
        write_reg(SEL_ARG_LO, 16'h5678);
        chk("R6 arg low only", req_arg, 32'hABCD_5678);
    endtask

    task automatic t_short_ok();
        logic [15:0] w;
        write_reg(SEL_CMD, 16'hA911);
        chk("R5 req pulse", 32'(req_valid), 32'h1);
        chk("R1 index", 32'(req_index), 32'd17);
        chk("R1 dir", 32'(req_dir), 32'h1);
        chk("R1 kind", 32'(req_kind), 32'h2);
        chk("R1 busy flag", 32'(req_busy), 32'h1);
        chk("R5 busy up", 32'(busy), 32'h1);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(req_valid), 32'h0);
        write_reg(SEL_CMD, 16'h0105);
        chk("R2 busy ignore req", 32'(req_valid), 32'h0);
        chk("R2 busy ignore index", 32'(req_index), 32'd17);
        respond(5'd4, mk(8'h00, 8'h00, 8'h09, 8'h00, 8'h10));
        chk("R11 done", 32'(status), 32'h0001);
        chk("R5 busy down", 32'(busy), 32'h0);
        word_at(3'd7, w); chk("R10 word7", 32'(w), 32'h0000);
        word_at(3'd6, w); chk("R10 word6", 32'(w), 32'h0900);
        word_at(3'd5, w); chk("R10 word5", 32'(w), 32'h1011);
        word_at(3'd0, w); chk("R10 word0", 32'(w), 32'h1A1B);
    endtask

    task automatic t_short_err();
        clear_status();
        write_reg(SEL_CMD, 16'h010D);
        respond(5'd4, mk(8'h80, 8'h00, 8'h00, 8'h00, 8'h40));
        chk("R9 error set", 32'(status), 32'h4001);
        write_reg(SEL_ST_CLR, 16'h0001);
        chk("R12 partial clear", 32'(status), 32'h4000);
        write_reg(SEL_CMD, 16'h010D);
        respond(5'd4, mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h40));
        chk("R9 error cleared", 32'(status), 32'h0001);
    endtask

    task automatic t_long();
        logic [15:0] w;
        clear_status();
        word_at(3'd5, w); chk("R10 word5 before", 32'(w), 32'h4041);
        write_reg(SEL_CMD, 16'h0202);
        word_at(3'd5, w); chk("R3 words cleared", 32'(w), 32'h0);
        respond(5'd15, mk(8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h50));
        chk("R7 timeout", 32'(status), 32'h0080);
        word_at(3'd7, w); chk("R7 no store", 32'(w), 32'h0);
        clear_status();
        write_reg(SEL_CMD, 16'h0202);
        respond(5'd16, mk(8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h60));
        chk("R7 long ok", 32'(status), 32'h0001);
        word_at(3'd7, w); chk("R10 long word7", 32'(w), 32'hDEAD);
        word_at(3'd6, w); chk("R10 long word6", 32'(w), 32'hBEEF);
        word_at(3'd4, w); chk("R10 long word4", 32'(w), 32'h6263);
    endtask

    task automatic t_ocr();
        clear_status();
        write_reg(SEL_CMD, 16'h0329);
        respond(5'd4, mk(8'h00, 8'hFF, 8'h80, 8'h00, 8'h00));
        chk("R8 not ready", 32'(status), 32'h1001);
        clear_status();
        write_reg(SEL_CMD, 16'h0329);
        respond(5'd4, mk(8'h80, 8'hFF, 8'h80, 8'h00, 8'h00));
        chk("R8 ready", 32'(status), 32'h0001);
    endtask

    task automatic t_rca();
        clear_status();
        write_reg(SEL_CMD, 16'h0603);
        respond(5'd4, mk(8'h00, 8'h00, 8'hE0, 8'h00, 8'h00));
        chk("R9 rca error", 32'(status), 32'h4001);
        clear_status();
        write_reg(SEL_CMD, 16'h0603);
        respond(5'd4, mk(8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00));
        chk("R9 rca upper ignored", 32'(status), 32'h0001);
        clear_status();
        write_reg(SEL_CMD, 16'h0603);
        respond(5'd4, mk(8'h00, 8'h00, 8'h00, 8'h08, 8'h00));
        chk("R9 rca bit3", 32'(status), 32'h4001);
        clear_status();
        write_reg(SEL_CMD, 16'h0603);
        respond(5'd3, mk(8'h00, 8'h00, 8'hE0, 8'h00, 8'h00));
        chk("R7 rca short", 32'(status), 32'h0080);
    endtask

    task automatic t_stop();
        clear_status();
        write_reg(SEL_CMD, 16'h090C);
        respond(5'd4, mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
        chk("R11 stop done", 32'(status), 32'h0005);
    endtask

    task automatic t_init();
        clear_status();
        write_reg(SEL_CMD, 16'h0080);
        chk("R4 no req", 32'(req_valid), 32'h0);
        chk("R4 no busy", 32'(busy), 32'h0);
        chk("R4 done only", 32'(status), 32'h0001);
        clear_status();
        write_reg(SEL_CMD, 16'h0085);
        chk("R4 init nonzero issues", 32'(req_valid), 32'h1);
        respond(5'd0, '0);
        chk("R4 init nonzero done", 32'(status), 32'h0001);
    endtask

    task automatic t_idle_rsp();
        logic [15:0] w;
        clear_status();
        respond(5'd16, mk(8'h11, 8'h22, 8'h33, 8'h44, 8'h55));
        chk("R12 idle rsp status", 32'(status), 32'h0);
        chk("R12 idle rsp busy", 32'(busy), 32'h0);
        word_at(3'd7, w); chk("R12 idle rsp word", 32'(w), 32'h0);
    endtask

    task automatic t_none();
        logic [15:0] w;
        write_reg(SEL_CMD, 16'h0000);
        chk("R7 none issues", 32'(req_valid), 32'h1);
        respond(5'd0, mk(8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h00));
        chk("R7 none done", 32'(status), 32'h0001);
        word_at(3'd7, w); chk("R7 none no store", 32'(w), 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_arg();
        t_short_ok();
        t_short_err();
        t_long();
        t_ocr();
        t_rca();
        t_stop();
        t_init();
        t_idle_rsp();
        t_none();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule